// File: doc/BRIEF.md
# Multi-Rate Timer and Interrupt Unit

This block keeps a family of memory-mapped time counters, all paced from a single system clock through tick enables that a prescaler derives from it. A fine step is the shortest period (0.625 ms at the default setting). Every 16 fine steps make a base step of 10 ms, and every 10 base steps make a slow step of 100 ms. A second base step sits half a base period later than the first, so two timers at the same rate never advance in the same cycle. The counters are a two-word elapsed-time clock, in which the low word carries into the high word, and four interval timers. Three of the interval timers count up and fire when they wrap past the largest positive value. The fourth counts fine steps down and fires when it reaches zero.

A timer that fires latches a pending request. A fixed-priority arbiter shows one pending request at a time, together with its vector address. The request is cleared when the core acknowledges it. A global inhibit input hides all requests without dropping them. Software reads every counter through a combinational read port and can overwrite any counter.

Top module: `mrt_unit`

## Requirements
- R1: The prescaler makes a fine step every FINE_CYC clock cycles, a base step every BASE_DIV fine steps and a slow step every SLOW_DIV base steps. Counting from the first clock edge after reset, the first fine step lands on edge FINE_CYC.
- R2: The elapsed-clock low word (word address octal 25) increments on each base step. When it steps from 0x3FFF it becomes 0 and the high word (octal 24) increments on the same edge. A wrap of either clock word raises no interrupt.
- R3: The waitlist timer (octal 26) increments on base steps that are offset by BASE_DIV/2 fine steps, which is half a base period, from the steps that drive the periodic timer (octal 27).
- R4: The periodic timer (base step), the waitlist timer (offset base step) and the autopilot timer (octal 30, slow step) each become 0 when they step from 0x3FFF, and on that same edge they latch a pending request.
- R5: The high-resolution timer (octal 31) decrements by one on each fine step while hires_run is 1 and it is nonzero. Going from 1 to 0 latches a request. At 0 it holds and raises nothing more. With hires_run at 0 it does not change.
- R6: rd_data shows, in the same cycle, the counter at word address addr. Any other address reads 0. A write to any other address changes no counter.
- R7: A write to a counter in the cycle of its step loads wr_data, and that step is lost. The step does not raise a request either.
- R8: The vectors, in priority order highest first, are octal 4004 (high-resolution), 4010 (autopilot), 4014 (waitlist) and 4020 (periodic). irq_vec carries the highest-priority pending vector while irq_req is 1, and 0 otherwise.
- R9: While irq_inhibit is 1, irq_req is 0. Pending requests are kept, and irq_ack has no effect.
- R10: irq_ack with irq_req at 1 clears only the presented request at the next edge. If that source fires again in the same cycle, it stays pending.
- R11: After reset, every counter reads 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the counter at addr |
| addr | input | 6 | Word address for read and write |
| wr_data | input | 15 | Value to load |
| rd_data | output | 15 | Counter at addr, combinational |
| hires_run | input | 1 | Lets the high-resolution timer count down |
| irq_inhibit | input | 1 | Global request mask |
| irq_ack | input | 1 | Acknowledge of the presented request |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | 12 | Vector address of the presented request |

## Verification
Two pairs of events can fall in one cycle. The first is a software write and a counter step. The bench finds the cycle of a base step by counting edges from reset, writes the periodic timer in exactly that cycle, and judges the outcome by reading the loaded value, not one more, and by later seeing a normal increment. The second is an acknowledge and a fresh firing of the same source. The bench reloads the high-resolution timer to 1 so that it reaches zero in the cycle of the acknowledge, and expects the request to remain presented with the same vector.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    localparam int CNT_W   = 15;
    localparam int ADDR_W  = 6;
    localparam int VEC_W   = 12;
    localparam int NUM_CNT = 6;
    localparam int NUM_IRQ = 4;

    localparam logic [CNT_W-1:0]  CNT_MAXPOS = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [ADDR_W-1:0] MAP_BASE   = 6'o24;
    localparam logic [VEC_W-1:0]  VEC_BASE   = 12'o4004;
    localparam int                VEC_STEP   = 4;

    // counter slots, in address order from MAP_BASE
    localparam int IX_HI   = 0;
    localparam int IX_LO   = 1;
    localparam int IX_WAIT = 2;
    localparam int IX_PER  = 3;
    localparam int IX_AUTO = 4;
    localparam int IX_FINE = 5;

    typedef enum logic {CNT_UP, CNT_DOWN} cnt_mode_e;

    typedef struct packed {
        logic fine;
        logic half;
        logic base;
        logic slow;
    } tick_t;

    function automatic cnt_mode_e mode_of(int ix);
        return (ix == IX_FINE) ? CNT_DOWN : CNT_UP;
    endfunction

    // interrupt slot (priority order) to counter slot
    function automatic int irq_src(int slot);
        case (slot)
            0:       return IX_FINE;
            1:       return IX_AUTO;
            2:       return IX_WAIT;
            default: return IX_PER;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] vector_of(int slot);
        return VEC_BASE + VEC_W'(VEC_STEP * slot);
    endfunction

endpackage

// File: rtl/mrt_tickgen.sv
module mrt_tickgen
    import mrt_pkg::*;
#(
    parameter int FINE_CYC = 31250,
    parameter int BASE_DIV = 16,
    parameter int SLOW_DIV = 10
) (
    input  logic  clk,
    input  logic  rst,
    output tick_t tk
);
    localparam int FW = (FINE_CYC > 1) ? $clog2(FINE_CYC) : 1;
    localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [FW-1:0] FINE_LAST = FW'(FINE_CYC - 1);
    localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);
    localparam logic [BW-1:0] HALF_LAST = BW'(BASE_DIV / 2 - 1);
    localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

    logic [FW-1:0] fine_q;
    logic [BW-1:0] base_q;
    logic [SW-1:0] slow_q;

    always_comb begin
        tk.fine = (fine_q == FINE_LAST);
        tk.base = tk.fine && (base_q == BASE_LAST);
        tk.half = tk.fine && (base_q == HALF_LAST);
        tk.slow = tk.base && (slow_q == SLOW_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q <= '0;
            base_q <= '0;
            slow_q <= '0;
        end else begin
            fine_q <= tk.fine ? '0 : fine_q + 1'b1;
            if (tk.fine) base_q <= tk.base ? '0 : base_q + 1'b1;
            if (tk.base) slow_q <= tk.slow ? '0 : slow_q + 1'b1;
        end
    end

endmodule

// File: rtl/mrt_cnt.sv
module mrt_cnt
    import mrt_pkg::*;
#(
    parameter cnt_mode_e MODE = CNT_UP,
    parameter int        W    = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] val,
    output logic         ev
);
    localparam logic [W-1:0] TOP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] nxt;

    generate
        if (MODE == CNT_UP) begin : g_up
            always_comb begin
                nxt = val;
                ev  = 1'b0;
                if (wr_en) begin
                    nxt = wr_val;
                end else if (step) begin
                    nxt = (val == TOP) ? '0 : val + 1'b1;
                    ev  = (val == TOP);
                end
            end
        end else begin : g_down
            always_comb begin
                nxt = val;
                ev  = 1'b0;
                if (wr_en) begin
                    nxt = wr_val;
                end else if (step && (val != '0)) begin
                    nxt = val - 1'b1;
                    ev  = (val == ONE);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) val <= '0;
        else     val <= nxt;
    end

endmodule

// File: rtl/mrt_irq_arb.sv
module mrt_irq_arb
    import mrt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] fire,
    input  logic               inhibit,
    input  logic               ack,
    output logic               req,
    output logic [VEC_W-1:0]   vec,
    output logic [NUM_IRQ-1:0] pend
);
    logic [NUM_IRQ-1:0] pick;

    // lowest slot wins
    always_comb begin
        pick = '0;
        for (int s = NUM_IRQ - 1; s >= 0; s--) begin
            if (pend[s]) pick = NUM_IRQ'(1) << s;
        end
    end

    always_comb begin
        req = (|pend) && !inhibit;
        vec = '0;
        if (req) begin
            for (int s = 0; s < NUM_IRQ; s++) begin
                if (pick[s]) vec = vector_of(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~((ack && req) ? pick : '0)) | fire;
    end

endmodule

// File: rtl/mrt_unit.sv
module mrt_unit
    import mrt_pkg::*;
#(
    parameter int FINE_CYC = 31250,
    parameter int BASE_DIV = 16,
    parameter int SLOW_DIV = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              hires_run,
    input  logic              irq_inhibit,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    tick_t              tk;
    logic [CNT_W-1:0]   cnt  [NUM_CNT];
    logic [NUM_CNT-1:0] hit;
    logic [NUM_CNT-1:0] step;
    logic [NUM_CNT-1:0] ev;
    logic [NUM_IRQ-1:0] fire;
    logic [NUM_IRQ-1:0] pend;
    logic               lo_wrap;
    logic               unused_wrap;

    mrt_tickgen #(
        .FINE_CYC(FINE_CYC),
        .BASE_DIV(BASE_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_tick (
        .clk(clk),
        .rst(rst),
        .tk (tk)
    );

    // carry from the low clock word, taken from its register state
    assign lo_wrap     = tk.base && !hit[IX_LO] && (cnt[IX_LO] == CNT_MAXPOS);
    assign unused_wrap = ev[IX_HI] ^ ev[IX_LO];

    always_comb begin
        step          = '0;
        step[IX_HI]   = lo_wrap;
        step[IX_LO]   = tk.base;
        step[IX_WAIT] = tk.half;
        step[IX_PER]  = tk.base;
        step[IX_AUTO] = tk.slow;
        step[IX_FINE] = tk.fine && hires_run;
    end

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            assign hit[i] = wr_en && (addr == MAP_BASE + ADDR_W'(i));
            mrt_cnt #(
                .MODE(mode_of(i)),
                .W   (CNT_W)
            ) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .step  (step[i]),
                .wr_en (hit[i]),
                .wr_val(wr_data),
                .val   (cnt[i]),
                .ev    (ev[i])
            );
        end
        for (genvar s = 0; s < NUM_IRQ; s++) begin : g_src
            assign fire[s] = ev[irq_src(s)];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == MAP_BASE + ADDR_W'(i)) rd_data = cnt[i];
        end
    end

    mrt_irq_arb u_arb (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .inhibit(irq_inhibit),
        .ack    (irq_ack),
        .req    (irq_req),
        .vec    (irq_vec),
        .pend   (pend)
    );

endmodule

// File: rtl/mrt_unit_chk.sv
module mrt_unit_chk
    import mrt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               hires_run,
    input logic               irq_inhibit,
    input logic               irq_ack,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [NUM_IRQ-1:0] pend,
    input logic [CNT_W-1:0]   hires_val,
    input logic [CNT_W-1:0]   per_val,
    input logic               base_tick
);
    localparam logic [ADDR_W-1:0] A_FINE = MAP_BASE + ADDR_W'(IX_FINE);
    localparam logic [ADDR_W-1:0] A_PER  = MAP_BASE + ADDR_W'(IX_PER);

    // R9
    inhibit_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq_inhibit |-> !irq_req);

    // R8
    vec_range_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec == 12'o4004 || irq_vec == 12'o4010 ||
                     irq_vec == 12'o4014 || irq_vec == 12'o4020));

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_ack |=> ((pend & $past(pend)) == $past(pend)));

    // R5
    hires_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!hires_run && !(wr_en && addr == A_FINE)) |=> $stable(hires_val));

    // R4
    periodic_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (base_tick && per_val == CNT_MAXPOS && !(wr_en && addr == A_PER))
        |=> (pend[3] && per_val == '0));

endmodule

bind mrt_unit mrt_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .hires_run  (hires_run),
    .irq_inhibit(irq_inhibit),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .pend       (pend),
    .hires_val  (cnt[5]),
    .per_val    (cnt[3]),
    .base_tick  (tk.base)
);

// File: tb/test_mrt_unit.sv
module test_mrt_unit;
    localparam logic [5:0] A_HI = 6'o24, A_LO = 6'o25, A_WAIT = 6'o26,
                           A_PER = 6'o27, A_AUTO = 6'o30, A_FINE = 6'o31;
    localparam logic [11:0] V_FINE = 12'o4004, V_AUTO = 12'o4010,
                            V_WAIT = 12'o4014, V_PER = 12'o4020;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [14:0] wr_data = '0;
    logic [14:0] rd_data;
    logic        hires_run = 1'b0;
    logic        irq_inhibit = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [11:0] irq_vec;
    int          total = 0;
    int          bad = 0;
    int          ecount = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    mrt_unit #(.FINE_CYC(2), .BASE_DIV(16), .SLOW_DIV(10)) i_mrt_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .hires_run(hires_run), .irq_inhibit(irq_inhibit),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rd(input logic [5:0] a, output logic [14:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [5:0] a, input logic [14:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        edges(1);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        edges(1);
        irq_ack = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; irq_ack = 1'b0;
        irq_inhibit = 1'b0; hires_run = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
    endtask

    task automatic wait_read(input logic [5:0] a, input logic [14:0] target,
                             input int limit, input string req);
        logic [14:0] v;
        int n = 0;
        rd(a, v);
        while (v != target && n < limit) begin
            edges(1);
            rd(a, v);
            n++;
        end
        check(req, v, target);
    endtask

    task automatic t_reset();
        logic [14:0] v;
        do_reset();
        for (int i = 0; i < 6; i++) begin
            rd(A_HI + 6'(i), v);
            check("R11 counter after reset", v, 0);
        end
        check("R11 no request", irq_req, 0);
        check("R11 vector idle", irq_vec, 0);
    endtask

    task automatic t_rates();
        logic [14:0] v;
        do_reset();
        edges(16);                       // 8 fine steps
        rd(A_WAIT, v); check("R3 waitlist at half period", v, 1);
        rd(A_PER, v);  check("R3 periodic not yet", v, 0);
        edges(16);                       // 16 fine steps
        rd(A_LO, v);   check("R1 low word one base step", v, 1);
        rd(A_PER, v);  check("R1 periodic one base step", v, 1);
        rd(A_WAIT, v); check("R3 waitlist unchanged", v, 1);
        edges(288);                      // 160 fine steps
        rd(A_LO, v);   check("R1 low word ten", v, 10);
        rd(A_AUTO, v); check("R1 autopilot slow step", v, 1);
        rd(A_FINE, v); check("R5 hires idle without run", v, 0);
        edges(16);                       // 168 fine steps
        rd(A_WAIT, v); check("R3 waitlist leads by half", v, 11);
        rd(A_PER, v);  check("R3 periodic stays", v, 10);
    endtask

    task automatic t_cascade();
        logic [14:0] v;
        do_reset();
        wr(A_HI, 15'd5);
        wr(A_LO, 15'h3FFF);
        wait_read(A_LO, 15'd0, 80, "R2 low word wraps");
        rd(A_HI, v); check("R2 carry into high word", v, 6);
        check("R2 no request on clock wrap", irq_req, 0);
    endtask

    task automatic t_overflow();
        logic [14:0] v;
        do_reset();
        wr(A_PER, 15'h3FFF);
        wait_read(A_PER, 15'd0, 80, "R4 periodic wraps");
        check("R4 periodic request", irq_req, 1);
        check("R8 periodic vector", irq_vec, V_PER);
        ack();
        check("R10 cleared after ack", irq_req, 0);
        wr(A_WAIT, 15'h3FFF);
        wait_read(A_WAIT, 15'd0, 80, "R4 waitlist wraps");
        check("R8 waitlist vector", irq_vec, V_WAIT);
        ack();
        wr(A_AUTO, 15'h3FFF);
        wait_read(A_AUTO, 15'd0, 700, "R4 autopilot wraps");
        check("R8 autopilot vector", irq_vec, V_AUTO);
        ack();
        check("R10 all clear", irq_req, 0);
        rd(A_PER, v); check("R4 periodic keeps counting", v != 0, 1);
    endtask

    task automatic t_hires();
        logic [14:0] v;
        do_reset();
        wr(A_FINE, 15'd3);
        edges(10);
        rd(A_FINE, v); check("R5 frozen without run", v, 3);
        hires_run = 1'b1;
        wait_read(A_FINE, 15'd0, 40, "R5 counts down to zero");
        check("R5 request at zero", irq_req, 1);
        check("R8 hires vector", irq_vec, V_FINE);
        ack();
        edges(20);
        rd(A_FINE, v); check("R5 holds at zero", v, 0);
        check("R5 no further request", irq_req, 0);
    endtask

    task automatic t_priority();
        do_reset();
        irq_inhibit = 1'b1;
        hires_run = 1'b1;
        wr(A_FINE, 15'd1);
        wr(A_PER, 15'h3FFF);
        edges(40);
        check("R9 masked request", irq_req, 0);
        check("R9 masked vector", irq_vec, 0);
        ack();
        irq_inhibit = 1'b0;
        #1;
        check("R9 pending kept through inhibit", irq_req, 1);
        check("R8 highest first", irq_vec, V_FINE);
        ack();
        check("R8 next in order", irq_vec, V_PER);
        ack();
        check("R10 nothing left", irq_req, 0);
    endtask

    task automatic t_collide();
        logic [14:0] v;
        // write against base step: step lands on edge 32
        do_reset();
        edges(31);
        wr(A_PER, 15'd100);
        rd(A_PER, v); check("R7 write beats step", v, 100);
        rd(A_LO, v);  check("R7 other counter stepped", v, 1);
        edges(32);
        rd(A_PER, v); check("R7 next step counts", v, 101);
        // acknowledge against a new firing of the same source
        hires_run = 1'b1;
        wr(A_FINE, 15'd1);
        edges(4);
        check("R10 first hires request", irq_vec, V_FINE);
        if (ecount % 2 != 0) edges(1);
        addr = A_FINE; wr_data = 15'd1; wr_en = 1'b1;
        edges(1);                        // odd edge: load, fine step next
        wr_en = 1'b0;
        irq_ack = 1'b1;
        edges(1);
        irq_ack = 1'b0;
        #1;
        check("R10 refire survives ack", irq_req, 1);
        check("R10 refire vector", irq_vec, V_FINE);
        ack();
        check("R10 cleared afterwards", irq_req, 0);
    endtask

    task automatic t_map();
        logic [14:0] v;
        do_reset();
        wr(A_HI, 15'h1111);
        wr(A_AUTO, 15'h0222);
        wr(6'o32, 15'h1234);
        wr(6'o23, 15'h0777);
        rd(A_HI, v);   check("R6 high word readback", v, 15'h1111);
        rd(A_AUTO, v); check("R6 autopilot readback", v, 15'h0222);
        rd(6'o32, v);  check("R6 unmapped reads zero", v, 0);
        rd(6'o23, v);  check("R6 below map reads zero", v, 0);
        rd(A_FINE, v); check("R6 stray write ignored", v, 0);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rates();
        t_cascade();
        t_overflow();
        t_hires();
        t_priority();
        t_collide();
        t_map();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule